// File: doc/BRIEF.md
# Command-Driven SPI Slave Shift Engine

This block is the slave end of an SPI link. A host loads a data word into a buffer, then writes a one-byte command. The command gives the word length, the sampling edge and a validity code. A falling edge on the slave-select pin starts the transfer. The engine then sends the buffer out on MISO, most significant bit first, and takes MOSI into the bottom of the same buffer. When the word is done, the buffer holds the received word.

A word shorter than the buffer is moved to the top of the buffer before the first clock. The host therefore always loads the word right-aligned, and it reads the received word back right-aligned. The command register also serves as the ready flag: the engine clears it when a transfer ends, fails or is refused. A status register says why a transfer failed. Each wait for an SCLK level change has its own stall timer, counted in ticks of a prescaler enable input. If the timer runs out, the transfer is abandoned.

The register interface has four word addresses: 0 command, 1 stall limit, 2 data buffer, 3 status. Writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset the command reads 0, status reads 0, the buffer reads 0, the stall limit reads 0xFF, and MISO is 0.
- R2: Command bits [3:0] set the word length: 1 to 15 select that many bits and 0 selects 16. The transfer ends after that many active SCLK edges, and the command then reads 0.
- R3: A command is accepted only if bit 4 is 1 and bit 5 is 0. Bit 7 has no effect. When slave-select falls with a nonzero command that breaks this rule, status bit 4 is set, the command is cleared to 0, and the buffer and MISO do not change.
- R4: Command bit 6 selects the active edge: 1 samples on the rising edge of SCLK and 0 on the falling edge. The opposite phase is the one in which MISO changes.
- R5: Before the first bit, a word of length L shorter than 16 is shifted left by 16-L, with zeros filling from the bottom. The bits sent on MISO are therefore buffer bits L-1 down to 0 as the host wrote them.
- R6: For each bit, in the inactive phase the current top buffer bit is driven on MISO and the buffer shifts left by one. On the active edge MOSI is stored into bit 0. After L bits the buffer reads the L received bits right-aligned, with zeros above them.
- R7: A transfer starts only on a falling edge of slave-select while the command is nonzero. A falling edge while the command is 0 changes nothing.
- R8: The stall timer is reloaded with the stall limit W at the start of each wait for an SCLK level. If the level has not appeared by the W-th tick (a limit of 0 acts as 1), the transfer stops, status bit 7 is set and the command is cleared.
- R9: Stall time advances only on cycles with the tick input high. Without ticks a stalled transfer waits indefinitely.
- R10: A rising edge of slave-select during a transfer stops it in the same way as a stall: status bit 7 is set and the command is cleared.
- R11: Writing a nonzero command clears the status register. Buffer writes are ignored while the command is nonzero. Command writes are ignored while a transfer is in progress.
- R12: MISO keeps its last driven value between bits and after a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address (0 command, 1 stall limit, 2 buffer, 3 status) |
| host_wdata | input | DATA_W | Register write data |
| host_rdata | output | DATA_W | Register read data for host_addr |
| tick | input | 1 | Prescaler enable, one stall time unit per high cycle |
| sclk_i | input | 1 | SPI serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |

## Verification
Each SPI pin passes through two synchroniser flops, and the engine registers the result one edge later. A change on SCLK or slave-select therefore shows up on MISO or in the registers at the third rising clock edge after it. A host write shows up at the next edge, and a read returns a value in the same cycle. The bench holds every SCLK phase for eight clocks. It samples MISO just before it drives the active edge, and it reads registers at least eight clocks after the last pin change, so each result is taken well after it is due and before the next stimulus. The stall test checks the command both early, when fewer than W ticks have passed, and late, after W ticks have passed.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OUT = 2'd1,
    ST_WAIT_IN  = 2'd2
  } eng_state_t;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_WDOG = 2'd1;
  localparam logic [1:0] A_BUF  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int CMD_W     = 8;
  localparam int STAT_W    = 8;
  localparam int CB_KEY    = 4;  // must be 1
  localparam int CB_MASTER = 5;  // must be 0
  localparam int CB_EDGE   = 6;  // 1: rising edge active
  localparam int SB_CMDERR = 4;
  localparam int SB_XFERR  = 7;

  function automatic logic cmd_ok(input logic [CMD_W-1:0] c);
    return c[CB_KEY] & ~c[CB_MASTER];
  endfunction

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int             N       = 1,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spi_stall_timer.sv
`timescale 1ns/1ps
module spi_stall_timer #(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            run,
  input  logic            tick,
  input  logic [WD_W-1:0] reload,
  output logic            expire
);
  logic [WD_W-1:0] cnt_q;

  assign expire = run & tick & (cnt_q <= WD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= reload;
    else if (run && tick && !expire) cnt_q <= cnt_q - WD_W'(1);
  end
endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              tick,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(DATA_W + 1);

  function automatic logic [CNT_W-1:0] word_len(input logic [CMD_W-1:0] c);
    if (c[LEN_W-1:0] == '0) return CNT_W'(DATA_W);
    return CNT_W'(c[LEN_W-1:0]);
  endfunction

  function automatic logic [DATA_W-1:0] align_word(input logic [DATA_W-1:0] w,
                                                   input logic [CNT_W-1:0] n);
    return w << (CNT_W'(DATA_W) - n);
  endfunction

  // synchronised pins {ss, mosi, sclk}
  logic [2:0] pins_s;
  logic       sclk_s, mosi_s, ss_s, ss_prev_q;
  spi_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, mosi_i, sclk_i}), .q(pins_s)
  );
  assign {ss_s, mosi_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_prev_q <= 1'b1;
    else        ss_prev_q <= ss_s;
  end

  // named internal events
  logic ss_fall, ss_rise, level_ok, start_ev, reject_ev, abort_ev, done_ev;
  logic tm_load, tm_run, tm_expire;

  eng_state_t           state_q;
  logic [CMD_W-1:0]     cmd_q;
  logic [STAT_W-1:0]    stat_q;
  logic [DATA_W-1:0]    dbuf_q;
  logic [WD_W-1:0]      wd_q;
  logic [CNT_W-1:0]     left_q;
  logic                 miso_q;

  assign ss_fall   = ss_prev_q & ~ss_s;
  assign ss_rise   = ~ss_prev_q & ss_s;
  assign level_ok  = ((state_q == ST_WAIT_OUT) && (sclk_s == ~cmd_q[CB_EDGE])) ||
                     ((state_q == ST_WAIT_IN)  && (sclk_s ==  cmd_q[CB_EDGE]));
  assign start_ev  = (state_q == ST_IDLE) && ss_fall && (cmd_q != '0) && cmd_ok(cmd_q);
  assign reject_ev = (state_q == ST_IDLE) && ss_fall && (cmd_q != '0) && !cmd_ok(cmd_q);
  assign abort_ev  = (state_q != ST_IDLE) && (ss_rise || tm_expire);
  assign done_ev   = (state_q == ST_WAIT_IN) && level_ok && !ss_rise && (left_q == CNT_W'(1));
  assign tm_load   = start_ev | level_ok;
  assign tm_run    = (state_q != ST_IDLE) && !level_ok;

  spi_stall_timer #(.WD_W(WD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .run(tm_run), .tick(tick),
    .reload(wd_q), .expire(tm_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      stat_q  <= '0;
      dbuf_q  <= '0;
      wd_q    <= '1;
      left_q  <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_WDOG) wd_q <= host_wdata[WD_W-1:0];
      if (abort_ev) begin
        stat_q[SB_XFERR] <= 1'b1;
        cmd_q            <= '0;
        state_q          <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (start_ev) begin
              dbuf_q  <= align_word(dbuf_q, word_len(cmd_q));
              left_q  <= word_len(cmd_q);
              state_q <= ST_WAIT_OUT;
            end else if (reject_ev) begin
              stat_q[SB_CMDERR] <= 1'b1;
              cmd_q             <= '0;
            end else if (host_wr) begin
              if (host_addr == A_CMD) begin
                cmd_q <= host_wdata[CMD_W-1:0];
                if (host_wdata[CMD_W-1:0] != '0) stat_q <= '0;
              end else if (host_addr == A_BUF && cmd_q == '0) begin
                dbuf_q <= host_wdata;
              end
            end
          end
          ST_WAIT_OUT: begin
            if (level_ok) begin
              miso_q  <= dbuf_q[DATA_W-1];
              dbuf_q  <= dbuf_q << 1;
              state_q <= ST_WAIT_IN;
            end
          end
          ST_WAIT_IN: begin
            if (level_ok) begin
              dbuf_q[0] <= mosi_s;
              left_q    <= left_q - CNT_W'(1);
              if (done_ev) begin
                cmd_q   <= '0;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_WAIT_OUT;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign miso_o = miso_q;

  always_comb begin
    case (host_addr)
      A_CMD:   host_rdata = DATA_W'(cmd_q);
      A_WDOG:  host_rdata = DATA_W'(wd_q);
      A_BUF:   host_rdata = dbuf_q;
      default: host_rdata = DATA_W'(stat_q);
    endcase
  end

  // assertions beside the engine
  AST_BUSY_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (cmd_q != '0));                                  // R2
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (stat_q[SB_CMDERR] && cmd_q == '0 && state_q == ST_IDLE && $stable(dbuf_q))); // R3
  AST_STALL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    tm_expire |=> (stat_q[SB_XFERR] && cmd_q == '0));                        // R8
  AST_NO_TICK_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !tm_expire);                                                    // R9
  AST_SS_RISE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && ss_rise) |=> (stat_q[SB_XFERR] && state_q == ST_IDLE)); // R10
  AST_BUF_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_BUF && cmd_q != '0 && state_q == ST_IDLE && !ss_fall) |=> $stable(dbuf_q)); // R11
  AST_MISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_WAIT_OUT) |=> $stable(miso_o));                            // R12
endmodule

// File: tb/tb_spi_cmd_slave.sv
`timescale 1ns/1ps
module tb_spi_cmd_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        tick = 1'b0;
  logic        sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic        miso;

  int  nchk = 0, nfail = 0, tcnt = 0;
  bit  tick_en = 1'b0, done = 1'b0;

  spi_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tick(tick),
    .sclk_i(sclk), .mosi_i(mosi), .ss_n_i(ss_n), .miso_o(miso)
  );

  initial forever #2.5 clk = ~clk;

  // prescaler: one tick every fourth cycle when enabled
  initial forever begin
    @(negedge clk);
    tick = tick_en && (tcnt % 4 == 0);
    tcnt++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  function automatic logic [15:0] keep_low(input logic [15:0] w, input int n);
    logic [15:0] r = 16'h0;
    for (int i = 0; i < n; i++) r[i] = w[i];
    return r;
  endfunction

  // master side: MOSI sent MSB first, MISO gathered right-aligned
  task automatic xfer(input bit rising, input int nbits, input logic [15:0] mw,
                      output logic [15:0] got);
    got = 16'h0;
    sclk = ~rising;
    idle(8);
    ss_n = 1'b0;
    idle(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = mw[nbits-1-i];
      idle(8);
      got = {got[14:0], miso};
      sclk = rising;
      idle(8);
      sclk = ~rising;
    end
    idle(8);
    ss_n = 1'b1;
    idle(8);
  endtask

  task automatic run_word(input string tag, input logic [7:0] cmd, input int nbits,
                          input logic [15:0] tx, input logic [15:0] rx);
    logic [15:0] got, v;
    hw(2'd2, tx);
    hw(2'd0, {8'h0, cmd});
    xfer(cmd[6], nbits, rx, got);
    chk({tag, " R5 R6 miso word"}, got, keep_low(tx, nbits));
    rd(2'd2, v); chk({tag, " R6 received buffer"}, v, keep_low(rx, nbits));
    rd(2'd0, v); chk({tag, " R2 command cleared"}, v, 16'h0);
    rd(2'd3, v); chk({tag, " R8 no stall abort"}, v, 16'h0);
    idle(20);
    chk({tag, " R12 miso holds last bit"}, {15'h0, miso}, {15'h0, tx[0]});
  endtask

  initial begin
    logic [15:0] v;
    logic        m0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd(2'd0, v); chk("R1 command", v, 16'h0);
    rd(2'd1, v); chk("R1 stall limit", v, 16'h00FF);
    rd(2'd2, v); chk("R1 buffer", v, 16'h0);
    rd(2'd3, v); chk("R1 status", v, 16'h0);
    chk("R1 miso", {15'h0, miso}, 16'h0);

    // normal transfers with ticks running: limit reloaded each phase
    hw(2'd1, 16'd6);
    tick_en = 1'b1;
    run_word("rise16", 8'h50, 16, 16'hA5C3, 16'h3C96);    // R4 R2 length 0 -> 16
    run_word("fall12", 8'h1C, 12, 16'h0ABC, 16'h05A5);    // R4 falling, R5 align
    run_word("rise1 bit7", 8'hD1, 1, 16'h0001, 16'h0001); // R3 bit7 ignored
    run_word("fall5", 8'h95, 5, 16'h0013, 16'h000C);      // R4 R5
    tick_en = 1'b0;

    // R3 rejection: bit 5 set
    hw(2'd2, 16'h1234);
    hw(2'd0, 16'h0030);
    m0 = miso;
    sclk = 1'b0; ss_n = 1'b0; idle(8); ss_n = 1'b1; idle(8);
    rd(2'd3, v); chk("R3 status bit4 on bad cmd", v, 16'h0010);
    rd(2'd0, v); chk("R3 bad cmd cleared", v, 16'h0);
    rd(2'd2, v); chk("R3 buffer untouched", v, 16'h1234);
    chk("R3 miso untouched", {15'h0, miso}, {15'h0, m0});
    // R3 rejection: bit 4 clear; R11 status cleared by new command
    hw(2'd0, 16'h0045);
    rd(2'd3, v); chk("R11 status cleared by write", v, 16'h0);
    ss_n = 1'b0; idle(8); ss_n = 1'b1; idle(8);
    rd(2'd3, v); chk("R3 key bit missing", v, 16'h0010);

    // R7 select with zero command
    ss_n = 1'b0; idle(8); ss_n = 1'b1; idle(8);
    rd(2'd2, v); chk("R7 buffer kept", v, 16'h1234);
    rd(2'd3, v); chk("R7 status kept", v, 16'h0010);
    rd(2'd0, v); chk("R7 command stays 0", v, 16'h0);

    // R11 buffer locked while command pending
    hw(2'd0, 16'h0050);
    hw(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R11 buffer write ignored", v, 16'h1234);

    // R9 stalled without ticks, then R10 select released
    sclk = 1'b0; ss_n = 1'b0;
    idle(200);
    rd(2'd0, v); chk("R9 still busy", v, 16'h0050);
    rd(2'd3, v); chk("R9 no error", v, 16'h0);
    hw(2'd0, 16'h0051);
    rd(2'd0, v); chk("R11 command write ignored when busy", v, 16'h0050);
    ss_n = 1'b1; idle(8);
    rd(2'd3, v); chk("R10 abort flag", v, 16'h0080);
    rd(2'd0, v); chk("R10 command cleared", v, 16'h0);

    // R8 stall timeout
    hw(2'd1, 16'd3);
    hw(2'd0, 16'h0050);
    tick_en = 1'b1;
    ss_n = 1'b0;
    idle(5);
    rd(2'd0, v); chk("R8 not yet expired", v, 16'h0050);
    idle(40);
    rd(2'd3, v); chk("R8 stall flag", v, 16'h0080);
    rd(2'd0, v); chk("R8 command cleared", v, 16'h0);
    ss_n = 1'b1; tick_en = 1'b0;
    idle(8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule